// File: doc/BRIEF.md
# Saturating Fractional Floating-Point Multiplier

This block multiplies two 32-bit floating-point words and returns a 32-bit result word, a 4-bit condition status and two interrupt flags. Each word carries a 24-bit two's-complement fractional mantissa in bits 31..8, with bit 31 as the sign, and an 8-bit two's-complement exponent in bits 7..0. The exponents are added, the mantissas are multiplied as integers, and the product is realigned and renormalized. If the result falls outside the exponent range, it is either saturated to the largest magnitude of the right sign or forced to zero.

The caller presents the accumulator word and the derived operand together with a one-cycle `start`. Exactly one clock later, `done` pulses high, and the result, status and flags are valid in that cycle. A new operation may start on every cycle. Instruction decoding, addressing and register storage belong to the surrounding processor.

Top module: `fmul24`

## Requirements
- R1: `done` is high in the cycle right after each cycle with `start` high, and only then. The outputs are valid while `done` is high. After reset, `done`, `result`, `ovf_flag` and `unf_flag` are all zero.
- R2: If both mantissas are nonzero and the exponent sum exceeds +127, `ovf_flag` is set. The exponent field becomes 0x7F. The mantissa field becomes 0x7FFFFF when the operand signs agree and 0x800000 when they differ.
- R3: If both mantissas are nonzero and the exponent sum is below -128, `unf_flag` is set and the result word is 0x00000000.
- R4: Otherwise, the mantissa field is the upper 24 bits of the doubled 48-bit product, left-shifted until bits 31 and 30 of the result differ. The exponent is decremented once per shift. Lower bits are truncated and there is no rounding.
- R5: When both mantissas are 0x800000 (-1.0), the result mantissa is 0x400000 and the exponent is the sum plus one.
- R6: After the R5 adjustment, an exponent of +127 or more sets `ovf_flag`. The result is then 0x7FFFFF (positive product) or 0x800000 (negative product), with exponent 0x7F.
- R7: If normalization drives the exponent below -128, `unf_flag` is set and the result word is zero.
- R8: A zero mantissa in either operand gives a result word of zero, status 0010 and no flags, whatever the exponents are.
- R9: `status` is 0010 for a zero result mantissa, 0001 for a negative result and 0100 for a positive result. This includes saturated and forced-zero results.
- R10: `ovf_flag` and `unf_flag` are never high together, and are only high while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operands valid, begin a multiply |
| acc_word | input | 32 | Accumulator operand: mantissa 31..8, exponent 7..0 |
| opnd_word | input | 32 | Derived operand, same layout |
| done | output | 1 | One-cycle result-valid pulse |
| result | output | 32 | Product word, same layout |
| status | output | 4 | Condition status (0010 zero, 0001 negative, 0100 positive) |
| ovf_flag | output | 1 | Exponent overflow, result saturated |
| unf_flag | output | 1 | Exponent underflow, result zeroed |

## Verification
The hardest cases to reach are the ones that depend on the exponent only after the mantissa work is done. These are the -1.0 × -1.0 adjustment pushing the exponent to +127, and normalization of unnormalized mantissas pushing it below -128. Random operands almost never reach them. The bench therefore drives directed words with both mantissas at 0x800000 and an exponent sum of 126, and minimum-exponent operands whose small mantissas need several normalizing shifts. A negative mantissa such as 0xC00000 is also driven, to exercise the two-shift normalization of negative products. Random words, including zero and unnormalized mantissas, are compared against a behavioural model built on integer arithmetic.

// File: rtl/fmul24.sv
module fmul24 #(
  parameter int MW = 24,
  parameter int EW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [MW+EW-1:0] acc_word,
  input  logic [MW+EW-1:0] opnd_word,
  output logic             done,
  output logic [MW+EW-1:0] result,
  output logic [3:0]       status,
  output logic             ovf_flag,
  output logic             unf_flag
);
  localparam int WW = MW + EW;
  localparam int PW = 2 * MW;
  localparam int NW = EW + 2;
  localparam int KW = $clog2(PW);
  localparam logic signed [NW-1:0] EMAX = NW'((2 ** (EW - 1)) - 1);
  localparam logic signed [NW-1:0] EMIN = NW'(-(2 ** (EW - 1)));
  localparam logic [MW-1:0] M_POS  = {1'b0, {(MW-1){1'b1}}};
  localparam logic [MW-1:0] M_NEG  = {1'b1, {(MW-1){1'b0}}};
  localparam logic [MW-1:0] M_HALF = {2'b01, {(MW-2){1'b0}}};
  localparam logic [EW-1:0] E_TOP  = {1'b0, {(EW-1){1'b1}}};

  logic [MW-1:0] a_m, b_m;
  logic [EW-1:0] a_e, b_e;
  assign a_m = acc_word[WW-1:EW];
  assign a_e = acc_word[EW-1:0];
  assign b_m = opnd_word[WW-1:EW];
  assign b_e = opnd_word[EW-1:0];

  logic any_zero;
  assign any_zero = (a_m == '0) || (b_m == '0);

  logic signed [NW-1:0] n_sum, n_fix, n_norm;
  assign n_sum = {{2{a_e[EW-1]}}, a_e} + {{2{b_e[EW-1]}}, b_e};

  logic [PW-2:0] prod;
  assign prod = (PW-1)'($signed({{MW{a_m[MW-1]}}, a_m}) * $signed({{MW{b_m[MW-1]}}, b_m}));

  logic [PW-1:0] p_sh, p_fix;
  logic          special;
  assign p_sh    = {prod, 1'b0};
  assign special = (p_sh[PW-1:MW] == M_NEG);
  assign p_fix   = special ? {M_HALF, {MW{1'b0}}} : p_sh;
  assign n_fix   = n_sum + NW'(special);

  logic [PW-2:0] y;
  logic [KW-1:0] k;
  assign y = p_fix[PW-2:0] ^ {(PW-1){p_fix[PW-1]}};

  always_comb begin
    k = '0;
    for (int i = 0; i < PW - 1; i++)
      if (y[i]) k = KW'(PW - 2 - i);
  end

  logic [MW-1:0] m_norm;
  assign n_norm = n_fix - NW'(k);
  assign m_norm = MW'((p_fix << k) >> MW);

  logic [WW-1:0] nx_res;
  logic          nx_ovf, nx_unf;
  logic [3:0]    nx_st;

  always_comb begin
    nx_res = '0;
    nx_ovf = 1'b0;
    nx_unf = 1'b0;
    if (any_zero) begin
      nx_res = '0;
    end else if (n_sum > EMAX) begin
      nx_ovf = 1'b1;
      nx_res = {(a_m[MW-1] == b_m[MW-1]) ? M_POS : M_NEG, E_TOP};
    end else if (n_sum < EMIN) begin
      nx_unf = 1'b1;
    end else if (n_fix >= EMAX) begin
      nx_ovf = 1'b1;
      nx_res = {p_fix[PW-1] ? M_NEG : M_POS, E_TOP};
    end else if (n_norm < EMIN) begin
      nx_unf = 1'b1;
    end else begin
      nx_res = {m_norm, n_norm[EW-1:0]};
    end
  end

  assign nx_st = (nx_res[WW-1:EW] == '0) ? 4'b0010 :
                 nx_res[WW-1]            ? 4'b0001 : 4'b0100;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      result   <= '0;
      status   <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
    end else begin
      done     <= start;
      ovf_flag <= start & nx_ovf;
      unf_flag <= start & nx_unf;
      if (start) begin
        result <= nx_res;
        status <= nx_st;
      end
    end
  end
endmodule

module fmul24_chk #(
  parameter int MW = 24,
  parameter int EW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [MW+EW-1:0] acc_word,
  input logic [MW+EW-1:0] opnd_word,
  input logic             done,
  input logic [MW+EW-1:0] result,
  input logic [3:0]       status,
  input logic             ovf_flag,
  input logic             unf_flag
);
  localparam int WW = MW + EW;

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R1
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start)); // R1
  AST_SATURATED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |-> (result[EW-1:0] == {1'b0, {(EW-1){1'b1}}}) &&
                 ((result[WW-1:EW] == {1'b0, {(MW-1){1'b1}}}) ||
                  (result[WW-1:EW] == {1'b1, {(MW-1){1'b0}}}))); // R2
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unf_flag |-> (result == '0) && (status == 4'b0010)); // R3
  AST_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[WW-1:EW] != '0) |-> (result[WW-1] != result[WW-2])); // R4
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (acc_word[WW-1:EW] == '0 || opnd_word[WW-1:EW] == '0)) |=>
      (result == '0) && !ovf_flag && !unf_flag); // R8
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(status) == 1) && ((status == 4'b0001) == result[WW-1])); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag || unf_flag) |-> done && !(ovf_flag && unf_flag)); // R10
endmodule

bind fmul24 fmul24_chk #(.MW(MW), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .acc_word(acc_word),
  .opnd_word(opnd_word), .done(done), .result(result), .status(status),
  .ovf_flag(ovf_flag), .unf_flag(unf_flag));

// File: tb/fmul24_bench.sv
module fmul24_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] acc_word = '0, opnd_word = '0;
  logic        done, ovf_flag, unf_flag;
  logic [31:0] result;
  logic [3:0]  status;

  int checks = 0, fails = 0;
  logic [37:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  fmul24 u_fmul24 (.clk(clk), .rst_n(rst_n), .start(start), .acc_word(acc_word),
    .opnd_word(opnd_word), .done(done), .result(result), .status(status),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag));

  function automatic logic [37:0] model(logic [31:0] a, logic [31:0] b);
    longint ma, mb, p;
    int n;
    logic [31:0] r;
    logic ov, un;
    logic [3:0] st;
    ma = longint'($signed(a[31:8]));
    mb = longint'($signed(b[31:8]));
    n  = int'($signed(a[7:0])) + int'($signed(b[7:0]));
    ov = 1'b0; un = 1'b0; r = '0;
    if (ma == 0 || mb == 0) begin
      r = '0;
    end else if (n > 127) begin
      ov = 1'b1;
      r = {((ma < 0) == (mb < 0)) ? 24'h7FFFFF : 24'h800000, 8'h7F};
    end else if (n < -128) begin
      un = 1'b1;
    end else begin
      p = ma * mb * 2;
      if (p == 64'sh8000_0000_0000) begin
        p = 64'sh4000_0000_0000;
        n = n + 1;
      end
      if (n >= 127) begin
        ov = 1'b1;
        r = {(p < 0) ? 24'h800000 : 24'h7FFFFF, 8'h7F};
      end else begin
        while (p >= -(64'sd1 <<< 46) && p < (64'sd1 <<< 46)) begin
          p = p * 2;
          n = n - 1;
        end
        if (n < -128) un = 1'b1;
        else r = {24'(p >>> 24), 8'(n)};
      end
    end
    st = (r[31:8] == 0) ? 4'b0010 : r[31] ? 4'b0001 : 4'b0100;
    return {r, st, ov, un};
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic [37:0] want, input string tag);
    @(negedge clk);
    start = 1'b1; acc_word = a; opnd_word = b;
    exp_q.push_back(want);
    tag_q.push_back(tag);
  endtask

  task automatic drive_m(input logic [31:0] a, input logic [31:0] b, input string tag);
    drive(a, b, model(a, b), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    start = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R1: done without pending start, got res=%h expected none", result);
        end else begin
          logic [37:0] w;
          string t;
          w = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if ({result, status, ovf_flag, unf_flag} !== w) begin
            fails++;
            $display("FAIL %s: got res=%h st=%b ov=%b un=%b expected res=%h st=%b ov=%b un=%b",
                     t, result, status, ovf_flag, unf_flag, w[37:6], w[5:2], w[1], w[0]);
          end
        end
      end else if (exp_q.size() != 0 && !start) begin
        checks++; fails++;
        $display("FAIL R1: done low with result pending, got done=0 expected done=1");
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1: watchdog expired, got hang expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || result !== '0 || ovf_flag !== 1'b0 || unf_flag !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset state got done=%b res=%h ov=%b un=%b expected all zero",
               done, result, ovf_flag, unf_flag);
    end
    // R4: 0.5*2^1 x 0.5*2^1 = 0.5*2^1
    drive(32'h400000_01, 32'h400000_01, {32'h400000_01, 4'b0100, 2'b00}, "R4");
    // R4: 0.75 x 0.75 = 0.5625
    drive(32'h600000_00, 32'h600000_00, {32'h480000_00, 4'b0100, 2'b00}, "R4");
    // R4 R9: -0.5 x 0.5 = -1.0*2^-2, two shifts on a negative product
    drive(32'hC00000_00, 32'h400000_00, {32'h800000_FE, 4'b0001, 2'b00}, "R4");
    // R5: -1.0*2^2 x -1.0*2^3
    drive(32'h800000_02, 32'h800000_03, {32'h400000_06, 4'b0100, 2'b00}, "R5");
    // R6: special case pushes exponent to 127
    drive(32'h800000_7E, 32'h800000_00, {32'h7FFFFF_7F, 4'b0100, 2'b10}, "R6");
    // R6: sum exactly 127 with negative product
    drive(32'hC00000_7F, 32'h400000_00, {32'h800000_7F, 4'b0001, 2'b10}, "R6");
    // R2: 100+100, signs differ
    drive(32'h400000_64, 32'hC00000_64, {32'h800000_7F, 4'b0001, 2'b10}, "R2");
    // R2: signs agree (both negative)
    drive(32'hA00000_70, 32'hC00000_70, {32'h7FFFFF_7F, 4'b0100, 2'b10}, "R2");
    // R3: -100 + -100
    drive(32'h400000_9C, 32'h400000_9C, {32'h0, 4'b0010, 2'b01}, "R3");
    // R7: -128 with one normalizing shift
    drive(32'h400000_80, 32'h400000_00, {32'h0, 4'b0010, 2'b01}, "R7");
    // R7: small unnormalized mantissas near the bottom
    drive(32'h000100_C0, 32'h000200_C0, {32'h0, 4'b0010, 2'b01}, "R7");
    // R8: zero operand with overflowing and underflowing exponents
    drive(32'h000000_64, 32'h400000_64, {32'h0, 4'b0010, 2'b00}, "R8");
    drive(32'hC00000_80, 32'h000000_80, {32'h0, 4'b0010, 2'b00}, "R8");
    // R9: status of a positive, unnormalized product
    drive(32'h000001_00, 32'h000001_00, {32'h400000_D3, 4'b0100, 2'b00}, "R9");
    idle();
    repeat (2) @(negedge clk);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (i % 3 == 0) begin a[7:0] = 8'($urandom_range(0, 40)); b[7:0] = 8'($urandom_range(0, 40)); end
      if (i % 7 == 0) a[31:8] = 24'(a[31:8] >> $urandom_range(1, 22));
      if (i % 23 == 0) b[31:8] = '0;
      if (i % 11 == 0) begin a[31:8] = 24'h800000; b[31:8] = 24'h800000; end
      drive_m(a, b, "R4");
      if (i % 5 == 0) idle();
    end
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    report();
  end
endmodule